// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block paces one successive-approximation conversion request, including optional hardware averaging, on a single system clock whose ticks of the ADC clock arrive as a plain enable input. A start pulse, qualified by a 5-bit channel number, launches a request. The block latches the channel and the configuration fields, then walks a fixed first-conversion overhead followed by N samples. Each sample has a programmable sampling window and a fixed base conversion window. During these windows it drives a sample/convert handshake to an external converter model. At the end of each base window it reads the converter's code.

The codes of all N samples are summed. When the last sample finishes, the block divides the sum by N (a right shift with truncation), masks the quotient to the selected resolution and writes it to the result register together with a one-cycle completion pulse. The total length of a request, counted in ADC clock ticks, is 6 + N × (25 + adder).

Top module: `convseq_top`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `smp_o` and `cnv_o` are low and `result_o` is zero.
- R2: A `start_i` pulse while idle with `chan_i` other than 31 raises `busy_o` in the next cycle and presents that channel on `chan_o`.
- R3: A start with `chan_i` equal to 31 (all ones) leaves the block idle.
- R4: While busy, a start pulse is ignored, and `chan_o` and the latched configuration stay unchanged. Configuration inputs are sampled only on an accepted start.
- R5: The first 6 ADC ticks of a request drive neither `smp_o` nor `cnv_o`. Each sample then takes A ticks with `smp_o` high, followed by 25 ticks with `cnv_o` high. A request lasts exactly 6 + N×(25 + A) ticks.
- R6: The sampling adder A is set by `lsmp_long_i` and `smp_sel_i`. With the long bit at 0, select values 0, 1, 2 and 3 give 3, 5, 7 and 9 ticks. With the long bit at 1, the same values give 13, 17, 21 and 25 ticks.
- R7: With `avg_en_i` at 0, N is 1. With `avg_en_i` at 1, `avg_cnt_i` values 0, 1, 2 and 3 give N = 4, 8, 16 and 32.
- R8: The converter code is sampled on the last convert tick of each sample. The result is the sum of the N codes shifted right by log2(N), with truncation, and it reaches 4095 for 32 full-scale codes.
- R9: `res_sel_i` value 0 masks the result to 0xFF, value 1 masks it to 0x3FF, and values 2 and 3 mask it to 0xFFF.
- R10: `done_o` is high for exactly one cycle, in the first cycle in which `busy_o` is low again. `result_o` changes only in that cycle.
- R11: Only cycles with `adck_en` high advance the sequence. In other cycles the phase outputs and `busy_o` hold.
- R12: `smp_o` and `cnv_o` are never high together, and neither is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adck_en | input | 1 | One-cycle ADC clock tick enable |
| start_i | input | 1 | Conversion request pulse |
| chan_i | input | 5 | Requested channel; 31 disables |
| lsmp_long_i | input | 1 | Selects the long range of sampling adders |
| smp_sel_i | input | 2 | Sampling adder select within the range |
| avg_en_i | input | 1 | Hardware averaging enable |
| avg_cnt_i | input | 2 | Averaging count select |
| res_sel_i | input | 2 | Resolution select (8/10/12 bits) |
| code_i | input | 12 | Code returned by the converter model |
| chan_o | output | 5 | Channel latched for the running request |
| smp_o | output | 1 | Sampling window active |
| cnv_o | output | 1 | Base conversion window active |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 12 | Averaged, masked result |

## Verification
The properties take for granted that `start_i`, `chan_i` and the configuration fields are driven from registers of the same clock domain, and that `adck_en` is a synchronous enable rather than a clock. The stimulus changes every input on the falling edge, holds the start pulse for one cycle, and drives `adck_en` either constantly high or as a random pattern so that the hold behaviour is exercised. Configuration and channel inputs are scrambled immediately after each accepted start, and a second start is issued in the middle of a request, so the properties on latching and ignoring are exercised with inputs that actually differ.

// File: rtl/convseq_pkg.sv
`timescale 1ns/1ps
package convseq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SAMPLE = 2'd2,
        PH_CONV   = 2'd3
    } phase_e;

    // Sampling adder minus one: short range 3,5,7,9; long range 13,17,21,25.
    function automatic logic [4:0] adder_minus1(input logic long_rng, input logic [1:0] sel);
        logic [4:0] v;
        if (long_rng) v = 5'd12 + {1'b0, sel, 2'b00};
        else          v = 5'd2  + {2'b00, sel, 1'b0};
        return v;
    endfunction

    // log2 of the number of averaged samples.
    function automatic logic [2:0] avg_shift(input logic en, input logic [1:0] cnt);
        return en ? (3'd2 + {1'b0, cnt}) : 3'd0;
    endfunction

endpackage

// File: rtl/convseq_cfg.sv
`timescale 1ns/1ps
module convseq_cfg #(
    parameter int CHAN_W       = 5,
    parameter int CODE_W       = 12,
    parameter int CNT_W        = 5,
    parameter int IDX_W        = 5,
    parameter int SH_W         = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic              long_i,
    input  logic [1:0]        sel_i,
    input  logic              avg_en_i,
    input  logic [1:0]        avg_cnt_i,
    input  logic [1:0]        res_i,
    output logic [CHAN_W-1:0] chan_o,
    output logic [CNT_W-1:0]  adder_m1_o,
    output logic [IDX_W-1:0]  last_idx_o,
    output logic [SH_W-1:0]   shift_o,
    output logic [CODE_W-1:0] mask_o
);
    import convseq_pkg::*;

    localparam int RES_LO  = CODE_W - 4;
    localparam int RES_MID = CODE_W - 2;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [CNT_W-1:0]  adder_m1;
        logic [IDX_W-1:0]  last_idx;
        logic [SH_W-1:0]   shift;
        logic [CODE_W-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        logic [2:0] sh;
        cfg_d = cfg_q;
        sh    = avg_shift(avg_en_i, avg_cnt_i);
        if (load_i) begin
            cfg_d.chan     = chan_i;
            cfg_d.adder_m1 = CNT_W'(adder_minus1(long_i, sel_i));
            cfg_d.shift    = SH_W'(sh);
            cfg_d.last_idx = ~({IDX_W{1'b1}} << sh);
            case (res_i)
                2'd0:    cfg_d.mask = {CODE_W{1'b1}} >> (CODE_W - RES_LO);
                2'd1:    cfg_d.mask = {CODE_W{1'b1}} >> (CODE_W - RES_MID);
                default: cfg_d.mask = {CODE_W{1'b1}};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign chan_o     = cfg_q.chan;
    assign adder_m1_o = cfg_q.adder_m1;
    assign last_idx_o = cfg_q.last_idx;
    assign shift_o    = cfg_q.shift;
    assign mask_o     = cfg_q.mask;

endmodule

// File: rtl/convseq_ctrl.sv
`timescale 1ns/1ps
module convseq_ctrl #(
    parameter int FIRST_TICKS = 6,
    parameter int BASE_TICKS  = 25,
    parameter int CNT_W       = 5,
    parameter int IDX_W       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_ok_i,
    input  logic [CNT_W-1:0] adder_m1_i,
    input  logic [IDX_W-1:0] last_idx_i,
    output logic             busy_o,
    output logic             smp_o,
    output logic             cnv_o,
    output logic             capture_o,
    output logic             final_o
);
    import convseq_pkg::*;

    localparam logic [CNT_W-1:0] FIRST_LAST = CNT_W'(FIRST_TICKS - 1);
    localparam logic [CNT_W-1:0] BASE_LAST  = CNT_W'(BASE_TICKS - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;
    logic cap_w, fin_w;

    always_comb begin
        seq_d = seq_q;
        cap_w = 1'b0;
        fin_w = 1'b0;
        case (seq_q.phase)
            PH_IDLE: begin
                if (start_ok_i) begin
                    seq_d.phase = PH_FIRST;
                    seq_d.cnt   = '0;
                    seq_d.idx   = '0;
                end
            end
            PH_FIRST: begin
                if (tick_i) begin
                    if (seq_q.cnt == FIRST_LAST) begin
                        seq_d.phase = PH_SAMPLE;
                        seq_d.cnt   = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            PH_SAMPLE: begin
                if (tick_i) begin
                    if (seq_q.cnt == adder_m1_i) begin
                        seq_d.phase = PH_CONV;
                        seq_d.cnt   = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            PH_CONV: begin
                if (tick_i) begin
                    if (seq_q.cnt == BASE_LAST) begin
                        cap_w     = 1'b1;
                        seq_d.cnt = '0;
                        if (seq_q.idx == last_idx_i) begin
                            fin_w       = 1'b1;
                            seq_d.phase = PH_IDLE;
                        end else begin
                            seq_d.idx   = seq_q.idx + 1'b1;
                            seq_d.phase = PH_SAMPLE;
                        end
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{phase: PH_IDLE, cnt: '0, idx: '0};
        else        seq_q <= seq_d;
    end

    assign busy_o    = (seq_q.phase != PH_IDLE);
    assign smp_o     = (seq_q.phase == PH_SAMPLE);
    assign cnv_o     = (seq_q.phase == PH_CONV);
    assign capture_o = cap_w;
    assign final_o   = fin_w;

endmodule

// File: rtl/convseq_accum.sv
`timescale 1ns/1ps
module convseq_accum #(
    parameter int CODE_W = 12,
    parameter int ACC_W  = 17,
    parameter int SH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              capture_i,
    input  logic              final_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [SH_W-1:0]   shift_i,
    input  logic [CODE_W-1:0] mask_i,
    output logic [CODE_W-1:0] result_o,
    output logic              done_o
);
    typedef struct packed {
        logic [ACC_W-1:0]  sum;
        logic [CODE_W-1:0] result;
        logic              done;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        logic [ACC_W-1:0] total;
        logic [ACC_W-1:0] avg;
        acc_d      = acc_q;
        acc_d.done = 1'b0;
        total      = acc_q.sum + ACC_W'(code_i);
        avg        = total >> shift_i;
        if (clear_i) begin
            acc_d.sum = '0;
        end else if (capture_i) begin
            acc_d.sum = total;
        end
        if (final_i) begin
            acc_d.result = avg[CODE_W-1:0] & mask_i;
            acc_d.done   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign result_o = acc_q.result;
    assign done_o   = acc_q.done;

endmodule

// File: rtl/convseq_top.sv
`timescale 1ns/1ps
module convseq_top #(
    parameter int CHAN_W       = 5,
    parameter int CODE_W       = 12,
    parameter int FIRST_TICKS  = 6,
    parameter int BASE_TICKS   = 25,
    parameter int MAX_AVG_LOG2 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adck_en,
    input  logic              start_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic              lsmp_long_i,
    input  logic [1:0]        smp_sel_i,
    input  logic              avg_en_i,
    input  logic [1:0]        avg_cnt_i,
    input  logic [1:0]        res_sel_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CHAN_W-1:0] chan_o,
    output logic              smp_o,
    output logic              cnv_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [CODE_W-1:0] result_o
);
    localparam int CNT_MAX = (BASE_TICKS > 25) ? BASE_TICKS : 25;
    localparam int CNT_W   = $clog2(CNT_MAX + FIRST_TICKS);
    localparam int IDX_W   = MAX_AVG_LOG2;
    localparam int SH_W    = $clog2(MAX_AVG_LOG2 + 1);
    localparam int ACC_W   = CODE_W + MAX_AVG_LOG2;
    localparam logic [CHAN_W-1:0] CHAN_OFF = {CHAN_W{1'b1}};

    logic             busy_w, start_ok_w, capture_w, final_w;
    logic [CNT_W-1:0] adder_m1_w;
    logic [IDX_W-1:0] last_idx_w;
    logic [SH_W-1:0]  shift_w;
    logic [CODE_W-1:0] mask_w;

    assign start_ok_w = start_i & ~busy_w & (chan_i != CHAN_OFF);

    convseq_cfg #(
        .CHAN_W(CHAN_W), .CODE_W(CODE_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .SH_W(SH_W)
    ) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start_ok_w),
        .chan_i     (chan_i),
        .long_i     (lsmp_long_i),
        .sel_i      (smp_sel_i),
        .avg_en_i   (avg_en_i),
        .avg_cnt_i  (avg_cnt_i),
        .res_i      (res_sel_i),
        .chan_o     (chan_o),
        .adder_m1_o (adder_m1_w),
        .last_idx_o (last_idx_w),
        .shift_o    (shift_w),
        .mask_o     (mask_w)
    );

    convseq_ctrl #(
        .FIRST_TICKS(FIRST_TICKS), .BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (adck_en),
        .start_ok_i (start_ok_w),
        .adder_m1_i (adder_m1_w),
        .last_idx_i (last_idx_w),
        .busy_o     (busy_w),
        .smp_o      (smp_o),
        .cnv_o      (cnv_o),
        .capture_o  (capture_w),
        .final_o    (final_w)
    );

    convseq_accum #(
        .CODE_W(CODE_W), .ACC_W(ACC_W), .SH_W(SH_W)
    ) accum_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_ok_w),
        .capture_i (capture_w),
        .final_i   (final_w),
        .code_i    (code_i),
        .shift_i   (shift_w),
        .mask_i    (mask_w),
        .result_o  (result_o),
        .done_o    (done_o)
    );

    assign busy_o = busy_w;

endmodule

// File: rtl/convseq_checker.sv
`timescale 1ns/1ps
module convseq_checker #(
    parameter int CHAN_W = 5,
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adck_en,
    input logic              start_i,
    input logic [CHAN_W-1:0] chan_i,
    input logic [CHAN_W-1:0] chan_o,
    input logic              smp_o,
    input logic              cnv_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [CODE_W-1:0] result_o
);
    localparam logic [CHAN_W-1:0] OFF = {CHAN_W{1'b1}};

    a_r12_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_o && cnv_o));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!smp_o && !cnv_o));

    a_r2_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && chan_i != OFF) |=> (busy_o && chan_o == $past(chan_i)));

    a_r3_off_channel: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && chan_i == OFF) |=> !busy_o);

    a_r4_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(chan_o));

    a_r5_first_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (!smp_o && !cnv_o));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r10_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !adck_en) |=> (busy_o && $stable(smp_o) && $stable(cnv_o)));

endmodule

bind convseq_top convseq_checker #(.CHAN_W(CHAN_W), .CODE_W(CODE_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .adck_en  (adck_en),
    .start_i  (start_i),
    .chan_i   (chan_i),
    .chan_o   (chan_o),
    .smp_o    (smp_o),
    .cnv_o    (cnv_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/convseq_top_tb_top.sv
`timescale 1ns/1ps
module convseq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adck_en = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  chan_i = '0;
    logic        lsmp_long_i = 1'b0;
    logic [1:0]  smp_sel_i = '0;
    logic        avg_en_i = 1'b0;
    logic [1:0]  avg_cnt_i = '0;
    logic [1:0]  res_sel_i = '0;
    logic [11:0] code_i = '0;
    logic [4:0]  chan_o;
    logic        smp_o, cnv_o, busy_o, done_o;
    logic [11:0] result_o;

    int n_chk = 0;
    int n_fail = 0;
    int en_mode = 0;
    int code_mode = 0;
    int cyc = 0;

    // reference model state
    bit m_busy = 0;
    bit m_done = 0;
    int m_ticks = 0;
    int m_total = 0;
    int m_add = 0;
    int m_n = 1;
    int m_sum = 0;
    int m_mask = 0;
    int m_result = 0;
    int m_chan = 0;

    always #2.5 clk = ~clk;

    convseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .adck_en(adck_en), .start_i(start_i), .chan_i(chan_i),
        .lsmp_long_i(lsmp_long_i), .smp_sel_i(smp_sel_i), .avg_en_i(avg_en_i),
        .avg_cnt_i(avg_cnt_i), .res_sel_i(res_sel_i), .code_i(code_i),
        .chan_o(chan_o), .smp_o(smp_o), .cnv_o(cnv_o), .busy_o(busy_o),
        .done_o(done_o), .result_o(result_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // ADC tick and converter code stimulus
    always @(negedge clk) begin
        adck_en = (en_mode == 0) ? 1'b1 : ($urandom_range(0, 2) != 0);
        code_i  = (code_mode == 1) ? 12'hFFF : 12'($urandom_range(0, 4095));
    end

    // behavioural reference: tick counting against the closed-form length
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_ticks = 0; m_sum = 0; m_result = 0; m_chan = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (adck_en) begin
                    if (m_ticks >= 6 && ((m_ticks - 6) % (25 + m_add)) == 24 + m_add)
                        m_sum += int'(code_i);
                    m_ticks++;
                    if (m_ticks == m_total) begin
                        m_busy = 0;
                        m_done = 1;
                        m_result = (m_sum / m_n) & m_mask;
                    end
                end
            end else if (start_i && chan_i != 5'd31) begin
                m_busy  = 1;
                m_ticks = 0;
                m_sum   = 0;
                m_chan  = int'(chan_i);
                m_add   = lsmp_long_i ? 13 + 4 * int'(smp_sel_i) : 3 + 2 * int'(smp_sel_i);
                m_n     = avg_en_i ? (1 << (int'(avg_cnt_i) + 2)) : 1;
                m_mask  = (res_sel_i == 2'd0) ? 'hFF : (res_sel_i == 2'd1) ? 'h3FF : 'hFFF;
                m_total = 6 + m_n * (25 + m_add);
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            bit e_smp, e_cnv;
            int r;
            e_smp = 0; e_cnv = 0;
            if (m_busy && m_ticks >= 6) begin
                r = (m_ticks - 6) % (25 + m_add);
                e_smp = (r < m_add);
                e_cnv = !e_smp;
            end
            check(busy_o == m_busy, "R2 R11 busy", int'(busy_o), int'(m_busy));
            check(smp_o == e_smp, "R5 R6 R12 sample window", int'(smp_o), int'(e_smp));
            check(cnv_o == e_cnv, "R5 R12 convert window", int'(cnv_o), int'(e_cnv));
            check(done_o == m_done, "R5 R6 R7 R10 done timing", int'(done_o), int'(m_done));
            check(int'(result_o) == m_result, "R8 R9 R10 result", int'(result_o), m_result);
            if (m_busy)
                check(int'(chan_o) == m_chan, "R4 channel hold", int'(chan_o), m_chan);
        end
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic run(input int ch, input int lng, input int sel, input int aen,
                       input int cnt, input int res, input int em, input int cm,
                       input bit interfere);
        en_mode = em;
        code_mode = cm;
        @(negedge clk);
        chan_i = 5'(ch); lsmp_long_i = lng[0]; smp_sel_i = 2'(sel);
        avg_en_i = aen[0]; avg_cnt_i = 2'(cnt); res_sel_i = 2'(res);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // scramble configuration: latched values must govern (R4)
        chan_i = 5'($urandom_range(0, 30)); lsmp_long_i = ~lsmp_long_i;
        smp_sel_i = ~smp_sel_i; avg_en_i = ~avg_en_i; avg_cnt_i = ~avg_cnt_i;
        res_sel_i = ~res_sel_i;
        if (interfere) begin
            repeat (20) @(negedge clk);
            chan_i = 5'd9;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            @(negedge clk);
            check(int'(chan_o) == ch, "R4 start ignored while busy", int'(chan_o), ch);
        end
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b0, "R1 reset control", int'({busy_o, done_o}), 0);
        check(smp_o == 1'b0 && cnv_o == 1'b0, "R1 reset phases", int'({smp_o, cnv_o}), 0);
        check(result_o == 12'd0, "R1 reset result", int'(result_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3: disabled channel starts nothing
        chan_i = 5'd31; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        check(busy_o == 1'b0, "R3 off channel stays idle", int'(busy_o), 0);

        run(3,  0, 0, 0, 0, 2, 0, 0, 1'b0);  // single sample, adder 3, 12-bit
        run(7,  1, 3, 1, 0, 0, 1, 0, 1'b1);  // 4 samples, adder 25, 8-bit, gapped ticks
        run(15, 0, 2, 1, 1, 1, 0, 0, 1'b0);  // 8 samples, adder 7, 10-bit
        run(0,  1, 1, 1, 3, 2, 1, 1, 1'b1);  // 32 full-scale samples, adder 17
        check(result_o == 12'hFFF, "R8 full-scale average", int'(result_o), 4095);
        run(30, 0, 3, 1, 2, 3, 0, 0, 1'b0);  // 16 samples, adder 9, reserved res -> 12-bit
        run(12, 1, 0, 0, 0, 0, 1, 1, 1'b0);  // adder 13, 8-bit full scale
        check(result_o == 12'h0FF, "R9 8-bit mask", int'(result_o), 255);
        run(21, 1, 2, 1, 0, 1, 0, 0, 1'b0);  // adder 21
        run(5,  0, 1, 0, 0, 1, 1, 1, 1'b0);  // adder 5, 10-bit full scale
        check(result_o == 12'h3FF, "R9 10-bit mask", int'(result_o), 1023);
        run(1,  1, 3, 1, 3, 2, 0, 0, 1'b0);  // 32 samples, random codes, truncation R8

        repeat (4) @(negedge clk);
        check(done_o == 1'b0 && busy_o == 1'b0, "R10 quiet after completion", int'({busy_o, done_o}), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule